// File: doc/BRIEF.md
# Vertical-Crosswise Parallel Multiplier

This block multiplies two unsigned operands with a column-parallel scheme. Every cross product of operand bits whose indices add up to the same value falls into one result column. All columns are summed at the same time, and a single carry pass then resolves them into the final product. The default operands are 4 bits wide and give an 8-bit product. A width parameter applies the same grouping rule to wider operands.

The combinational product is available on its own output. A build-time switch adds an output register with a valid flag. When that register is present, the product is captured on the clock edge where the input strobe is high, and the valid flag follows one cycle later. The register clears on a synchronous, active-high reset.

Top module: `vcm_mult`

## Requirements
- R1: `prodNow` equals the unsigned product `opA * opB` in all 2·W bits. It depends only on the current operands.
- R2: Column k is the count of bit pairs with `opA[i] & opB[j]` and i+j = k, plus the carry from column k−1. Product bit k is the lowest bit of that sum, and the remaining bits carry into column k+1. There are 2·W−1 columns, numbered 0 to 2·W−2.
- R3: The carry out of the last column, 2·W−2, becomes the top product bit 2·W−1. For example, 15 × 15 = 225 needs bit 7 set.
- R4: With the output register enabled, a rising clock edge where `inValid` is 1 and `rst` is 0 loads `prodReg` with that cycle's product.
- R5: `outValid` is 1 in the cycle after an edge where `inValid` was 1 without reset. It is 0 after any other edge.
- R6: An edge where `inValid` is 0 and `rst` is 0 leaves `prodReg` unchanged.
- R7: An edge where `rst` is 1 clears `prodReg` to zero and `outValid` to 0, even if `inValid` is 1.
- R8: If either operand is zero, `prodNow` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Strobe marking the operands as ready for capture |
| opA | input | W | Multiplicand, unsigned |
| opB | input | W | Multiplier, unsigned |
| prodNow | output | 2·W | Combinational product |
| prodReg | output | 2·W | Registered product |
| outValid | output | 1 | High for one cycle after a captured strobe |

## Verification
`prodNow` is due in the same cycle as its operands. The bench samples it 1 ns after driving the inputs on the falling edge, before the next rising edge. `prodReg` and `outValid` are due one rising edge after the strobe or reset. A bench model updates at that edge, and the registered outputs are compared 1 ns later. Every one of the 256 operand pairs is visited with a random strobe. Random traffic with occasional resets and directed cases then cover reset priority, hold and the top-carry boundary.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  // strobes from the control half to the datapath register
  typedef struct packed {
    logic clear;
    logic capture;
  } vcmStrobe_t;
endpackage

// File: rtl/vcm_ctrl.sv
module vcm_ctrl
  import vcm_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output vcmStrobe_t strobe,
  output logic       outValid
);
  // reset wins over a capture request
  assign strobe.clear   = rst;
  assign strobe.capture = inValid & ~rst;

  generate
    if (REGISTERED) begin : gRegValid
      logic validQ;
      always_ff @(posedge clk) begin
        if (rst) validQ <= 1'b0;
        else     validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : gPassValid
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/vcm_datapath.sv
module vcm_datapath
  import vcm_pkg::*;
#(
  parameter int  W          = 4,
  parameter bit  REGISTERED = 1'b1
) (
  input  logic           clk,
  input  vcmStrobe_t     strobe,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  output logic [2*W-1:0] prodNow,
  output logic [2*W-1:0] prodReg
);
  localparam int PW    = 2 * W;
  localparam int NCOL  = PW - 1;
  // a column holds at most W cross bits plus a carry below 2W
  localparam int SW    = $clog2(PW) + 1;

  // all columns summed from index-matched cross products, then one carry pass
  always_comb begin
    logic [SW-1:0] carry;
    logic [SW-1:0] colSum;
    carry   = '0;
    prodNow = '0;
    for (int k = 0; k < NCOL; k++) begin
      colSum = carry;
      for (int i = 0; i < W; i++) begin
        for (int j = 0; j < W; j++) begin
          if (i + j == k) colSum = colSum + SW'(opA[i] & opB[j]);
        end
      end
      prodNow[k] = colSum[0];
      carry      = colSum >> 1;
    end
    prodNow[PW-1] = carry[0];
  end

  generate
    if (REGISTERED) begin : gOutReg
      logic [PW-1:0] prodQ;
      always_ff @(posedge clk) begin
        if (strobe.clear)        prodQ <= '0;
        else if (strobe.capture) prodQ <= prodNow;
      end
      assign prodReg = prodQ;
    end else begin : gNoReg
      assign prodReg = prodNow;
    end
  endgenerate
endmodule

// File: rtl/vcm_mult.sv
module vcm_mult
  import vcm_pkg::*;
#(
  parameter int W          = 4,
  parameter bit REGISTERED = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  output logic [2*W-1:0] prodNow,
  output logic [2*W-1:0] prodReg,
  output logic           outValid
);
  vcmStrobe_t strobe;

  vcm_ctrl #(.REGISTERED(REGISTERED)) uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  vcm_datapath #(.W(W), .REGISTERED(REGISTERED)) uData (
    .clk(clk), .strobe(strobe), .opA(opA), .opB(opB),
    .prodNow(prodNow), .prodReg(prodReg)
  );
endmodule

// File: rtl/vcm_mult_checker.sv
module vcm_mult_checker #(
  parameter int W          = 4,
  parameter bit REGISTERED = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic           inValid,
  input logic [W-1:0]   opA,
  input logic [W-1:0]   opB,
  input logic [2*W-1:0] prodNow,
  input logic [2*W-1:0] prodReg,
  input logic           outValid
);
  logic [2*W-1:0] refProd;
  assign refProd = {{W{1'b0}}, opA} * {{W{1'b0}}, opB};

  AST_COMB_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    prodNow == refProd); // R1
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (opA == '0 || opB == '0) |-> prodNow == '0); // R8

  generate
    if (REGISTERED) begin : gRegChecks
      AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        inValid |=> prodReg == $past(refProd)); // R4
      AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
        inValid |=> outValid); // R5
      AST_VALID_LOW: assert property (@(posedge clk) disable iff (rst)
        !inValid |=> !outValid); // R5
      AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !inValid |=> $stable(prodReg)); // R6
      AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (prodReg == '0 && !outValid)); // R7
    end
  endgenerate
endmodule

bind vcm_mult vcm_mult_checker #(.W(W), .REGISTERED(REGISTERED)) uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
  .prodNow(prodNow), .prodReg(prodReg), .outValid(outValid)
);

// File: tb/tb_vcm_mult.sv
module tb_vcm_mult;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [W-1:0]  opA = '0;
  logic [W-1:0]  opB = '0;
  logic [PW-1:0] prodNow, prodReg;
  logic          outValid;

  int nTests = 0;
  int nFails = 0;
  bit finished = 1'b0;

  logic [PW-1:0] expReg   = '0;
  logic          expValid = 1'b0;

  always #2.5 clk = ~clk;

  vcm_mult #(.W(W), .REGISTERED(1'b1)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .prodNow(prodNow), .prodReg(prodReg), .outValid(outValid)
  );

  function automatic logic [PW-1:0] mulRef(input logic [W-1:0] a, input logic [W-1:0] b);
    int unsigned p;
    p = int'(a) * int'(b);
    return p[PW-1:0];
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic v, input logic r, input string req);
    opA = a; opB = b; inValid = v; rst = r;
    #1;
    check({req, " comb"}, prodNow, mulRef(a, b));
    @(posedge clk);
    if (r) begin expReg = '0; expValid = 1'b0; end
    else begin
      expValid = v;
      if (v) expReg = mulRef(a, b);
    end
    #1;
    check({req, " reg"}, prodReg, expReg);
    check({req, " valid"}, PW'(outValid), PW'(expValid));
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    step(4'd9, 4'd7, 1'b1, 1'b1, "R7 reset");
    step(4'd3, 4'd5, 1'b0, 1'b1, "R7 reset");
    // directed corners
    step(4'd15, 4'd15, 1'b1, 1'b0, "R3 top carry");
    step(4'd0, 4'd13, 1'b1, 1'b0, "R8 zero a");
    step(4'd11, 4'd0, 1'b1, 1'b0, "R8 zero b");
    step(4'd10, 4'd5, 1'b1, 1'b0, "R4 capture");
    step(4'd7, 4'd7, 1'b0, 1'b0, "R6 hold");
    step(4'd1, 4'd2, 1'b0, 1'b0, "R6 hold");
    step(4'd12, 4'd12, 1'b1, 1'b1, "R7 reset priority");
    step(4'd8, 4'd8, 1'b1, 1'b0, "R5 valid");
    // exhaustive pairs with random strobe
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        step(W'(a), W'(b), 1'($urandom), 1'b0, "R2 exhaustive");
      end
    end
    // random traffic with occasional reset
    for (int n = 0; n < 300; n++) begin
      step(W'($urandom), W'($urandom), 1'($urandom),
           ($urandom % 20) == 0, "R1 random");
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end
endmodule